// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit configuration words placed in a 4 KiB window and reached over a plain synchronous read/write bus with word addressing. The bank holds settings for the rest of the system: three PLL control words, three PLL configuration words, a reset-control word, a one-bit control word, read-only status words (lock status, PLL status, boot mode) and a general-purpose array of configuration words. It only stores values and does not generate clocks or drive pins.

Ordinary registers are protected by a write lock that is engaged out of reset. Software opens the lock by writing an unlock key to one write-only word and closes it by writing a lock key to another. Every word address is classified as read-write, read-only, write-only or unmapped. Any access that breaks that policy, or any write to a protected word while the lock is engaged, is dropped and marked by a single-cycle error strobe. An accepted write that sets bit 0 of the reset-control word emits a one-cycle soft-reset request.

Top module: `sysctl_lock_regs`

## Requirements
- R1: After reset the lock status word (byte offset 0x00C) reads 1. The PLL control words at 0x100, 0x104 and 0x108 read 0x0001A008. The PLL configuration words at 0x110, 0x114 and 0x118 read 0x00014000. PLL status (0x10C) reads 0x0000003F, boot mode (0x25C) reads 0x00000001, and the control word (0x000) and reset-control word (0x200) read 0.
- R2: A write to 0x004 whose data bits [15:0] equal 0x767B sets the lock status to 1, whatever bits [31:16] hold. Any other data written there leaves the lock status unchanged. Such a write never raises the error strobe.
- R3: A write to 0x008 whose data bits [15:0] equal 0xDF0D clears the lock status to 0, whatever bits [31:16] hold. Any other data written there leaves the lock status unchanged. Such a write never raises the error strobe.
- R4: While the lock status is 1, a write to any read-write word other than 0x000 is discarded and raises the error strobe. This includes the PLL words, the reset-control word and the configuration array.
- R5: A write to a read-only word (0x00C, 0x10C, 0x25C) or to an unmapped word is discarded and raises the error strobe.
- R6: A read of a write-only word (0x004, 0x008) or of an unmapped word raises the error strobe and returns the stored content, which is 0 for these words.
- R7: The control word at 0x000 keeps only bit 0 of written data, and bits [31:1] read as 0. It accepts writes whether or not the lock is engaged.
- R8: An accepted write to 0x200 with data bit 0 set drives soft_rst_req high for exactly the one cycle after the write. A write with bit 0 clear, or a discarded write, does not drive it. The word stores all 32 written bits.
- R9: Read data appears on bus_rdata the cycle after the read strobe and holds until the next read. access_err is high only during the cycle of the offending access.
- R10: Address bits [1:0] are ignored, so every access addresses a whole 32-bit word.
- R11: The configuration array of SCR_WORDS words starting at byte offset 0x700 is read-write. After unlocking, each word reads back the full value last written to it.
- R12: After unlocking, the PLL control and configuration words store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for the addressed word |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address within the window; bits [1:0] ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| access_err | output | 1 | Policy violation in the current cycle |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
The hardest situations to reach from the ports are the lock-dependent ones. Only a write whose low half exactly matches a key changes the lock, and its effect on every protected word is visible only through later reads. The bench therefore sweeps the whole 1024-word window three times: a write sweep while locked, a read-back that must still show reset contents, and a write sweep after unlocking followed by a read-back. Each sweep uses an address-derived pattern whose low half can never equal either key. Near-miss keys, keys with junk upper halves, the lock bypass of the control word, and soft-reset requests with the lock open and closed are driven one by one between the sweeps.

// File: rtl/slr_pkg.sv
package slr_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

  // word indices (byte offset / 4)
  localparam int unsigned W_CTRL      = 0;
  localparam int unsigned W_LOCK      = 1;
  localparam int unsigned W_UNLOCK    = 2;
  localparam int unsigned W_LKSTAT    = 3;
  localparam int unsigned W_PLL_CTRL0 = 64;
  localparam int unsigned W_PLL_STAT  = 67;
  localparam int unsigned W_PLL_CFG0  = 68;
  localparam int unsigned W_RSTCTL    = 128;
  localparam int unsigned W_BOOT      = 151;
  localparam int unsigned NUM_PLL     = 3;

  localparam logic [15:0] KEY_LOCK   = 16'h767B;
  localparam logic [15:0] KEY_UNLOCK = 16'hDF0D;

  localparam logic [31:0] RV_PLL_CTRL = 32'h0001_A008;
  localparam logic [31:0] RV_PLL_CFG  = 32'h0001_4000;
  localparam logic [31:0] RV_PLL_STAT = 32'h0000_003F;
  localparam logic [31:0] RV_BOOT     = 32'h0000_0001;
endpackage

// File: rtl/slr_acc_decode.sv
module slr_acc_decode
  import slr_pkg::*;
#(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned SCR_BASE  = 448,
  parameter int unsigned SCR_WORDS = 54,
  parameter int unsigned IDX_W     = 6
) (
  input  logic [WORD_W-1:0] word,
  output acc_e              cls,
  output logic              is_scr,
  output logic [IDX_W-1:0]  scr_idx
);
  logic [31:0] wi;
  assign wi = 32'(word);

  assign is_scr  = (wi >= SCR_BASE) && (wi < SCR_BASE + SCR_WORDS);
  assign scr_idx = is_scr ? IDX_W'(wi - SCR_BASE) : '0;

  always_comb begin
    cls = ACC_NONE;
    if (is_scr) begin
      cls = ACC_RW;
    end else begin
      case (wi)
        W_LOCK, W_UNLOCK:               cls = ACC_WO;
        W_LKSTAT, W_PLL_STAT, W_BOOT:   cls = ACC_RO;
        W_CTRL, W_RSTCTL:               cls = ACC_RW;
        default: begin
          if (wi >= W_PLL_CTRL0 && wi < W_PLL_CTRL0 + NUM_PLL) cls = ACC_RW;
          if (wi >= W_PLL_CFG0 && wi < W_PLL_CFG0 + NUM_PLL)   cls = ACC_RW;
        end
      endcase
    end
  end
endmodule

// File: rtl/slr_lock_ctrl.sv
module slr_lock_ctrl
  import slr_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  input  logic [15:0]       key,
  output logic              locked
);
  logic hit_lock, hit_unlock;
  assign hit_lock   = wr && (32'(word) == W_LOCK)   && (key == KEY_LOCK);
  assign hit_unlock = wr && (32'(word) == W_UNLOCK) && (key == KEY_UNLOCK);

  always_ff @(posedge clk) begin
    if (rst)             locked <= 1'b1;
    else if (hit_lock)   locked <= 1'b1;
    else if (hit_unlock) locked <= 1'b0;
  end
endmodule

// File: rtl/slr_regfile.sv
module slr_regfile
  import slr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned SCR_WORDS = 54,
  parameter int unsigned IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [WORD_W-1:0] word,
  input  logic              is_scr,
  input  logic [IDX_W-1:0]  scr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              locked,
  output logic [DATA_W-1:0] rdata,
  output logic              soft_rst_req
);
  logic [31:0] wi;
  assign wi = 32'(word);

  logic              ctrl_q;
  logic [DATA_W-1:0] rst_ctl_q;
  logic [DATA_W-1:0] pll_ctrl_q [NUM_PLL];
  logic [DATA_W-1:0] pll_cfg_q  [NUM_PLL];
  logic [DATA_W-1:0] rd_named, named_q, ram_q;
  logic              sel_scr_q;
  logic              soft_q;
  logic [DATA_W-1:0] ram [SCR_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= 1'b0;
      rst_ctl_q <= '0;
      soft_q    <= 1'b0;
    end else begin
      if (we && wi == W_CTRL)   ctrl_q    <= wdata[0];
      if (we && wi == W_RSTCTL) rst_ctl_q <= wdata;
      soft_q <= we && (wi == W_RSTCTL) && wdata[0];
    end
  end

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    localparam int unsigned CA = W_PLL_CTRL0 + g;
    localparam int unsigned FA = W_PLL_CFG0 + g;
    always_ff @(posedge clk) begin
      if (rst) begin
        pll_ctrl_q[g] <= DATA_W'(RV_PLL_CTRL);
        pll_cfg_q[g]  <= DATA_W'(RV_PLL_CFG);
      end else begin
        if (we && wi == CA) pll_ctrl_q[g] <= wdata;
        if (we && wi == FA) pll_cfg_q[g]  <= wdata;
      end
    end
  end

  always_comb begin
    rd_named = '0;
    case (wi)
      W_CTRL:     rd_named = DATA_W'(ctrl_q);
      W_LKSTAT:   rd_named = DATA_W'(locked);
      W_PLL_STAT: rd_named = DATA_W'(RV_PLL_STAT);
      W_RSTCTL:   rd_named = rst_ctl_q;
      W_BOOT:     rd_named = DATA_W'(RV_BOOT);
      default:    rd_named = '0;
    endcase
    for (int i = 0; i < NUM_PLL; i++) begin
      if (wi == W_PLL_CTRL0 + i) rd_named = pll_ctrl_q[i];
      if (wi == W_PLL_CFG0 + i)  rd_named = pll_cfg_q[i];
    end
  end

  // configuration array: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we && is_scr) ram[scr_idx] <= wdata;
    if (re)           ram_q <= ram[scr_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      named_q   <= '0;
      sel_scr_q <= 1'b0;
    end else if (re) begin
      named_q   <= rd_named;
      sel_scr_q <= is_scr;
    end
  end

  assign rdata        = sel_scr_q ? ram_q : named_q;
  assign soft_rst_req = soft_q;
endmodule

// File: rtl/sysctl_lock_regs.sv
module sysctl_lock_regs
  import slr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SCR_BASE  = 448,
  parameter int unsigned SCR_WORDS = 54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              access_err,
  output logic              soft_rst_req
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = (SCR_WORDS > 1) ? $clog2(SCR_WORDS) : 1;

  logic [WORD_W-1:0] word;
  logic [1:0]        addr_lsb_unused;
  acc_e              cls;
  logic              is_scr;
  logic [IDX_W-1:0]  scr_idx;
  logic              lock_q;
  logic              is_ctrl, wr_ok, wr_bad, rd_bad;

  assign word            = bus_addr[ADDR_W-1:2];
  assign addr_lsb_unused = bus_addr[1:0];
  assign is_ctrl         = (32'(word) == W_CTRL);

  slr_acc_decode #(
    .WORD_W(WORD_W), .SCR_BASE(SCR_BASE), .SCR_WORDS(SCR_WORDS), .IDX_W(IDX_W)
  ) u_dec (
    .word(word), .cls(cls), .is_scr(is_scr), .scr_idx(scr_idx)
  );

  slr_lock_ctrl #(.WORD_W(WORD_W)) u_lock (
    .clk(clk), .rst(rst), .wr(bus_wr), .word(word),
    .key(bus_wdata[15:0]), .locked(lock_q)
  );

  assign wr_ok  = bus_wr && (cls == ACC_RW) && (!lock_q || is_ctrl);
  assign wr_bad = bus_wr && ((cls == ACC_NONE) || (cls == ACC_RO) ||
                             ((cls == ACC_RW) && lock_q && !is_ctrl));
  assign rd_bad = bus_rd && ((cls == ACC_NONE) || (cls == ACC_WO));
  assign access_err = wr_bad || rd_bad;

  slr_regfile #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .SCR_WORDS(SCR_WORDS), .IDX_W(IDX_W)
  ) u_rf (
    .clk(clk), .rst(rst), .we(wr_ok), .re(bus_rd), .word(word),
    .is_scr(is_scr), .scr_idx(scr_idx), .wdata(bus_wdata), .locked(lock_q),
    .rdata(bus_rdata), .soft_rst_req(soft_rst_req)
  );
endmodule

// File: rtl/slr_checker.sv
module slr_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              access_err,
  input logic              soft_rst_req,
  input logic              lock_q
);
  logic [31:0] wa;
  logic        hi_unused;
  assign wa        = 32'(bus_addr[ADDR_W-1:2]);
  assign hi_unused = ^bus_wdata[DATA_W-1:16];

  a_r2_lock_key: assert property (@(posedge clk) disable iff (rst)
    bus_wr && wa == 1 && bus_wdata[15:0] == 16'h767B |=> lock_q);

  a_r3_unlock_key: assert property (@(posedge clk) disable iff (rst)
    bus_wr && wa == 2 && bus_wdata[15:0] == 16'hDF0D |=> !lock_q);

  // R2 / R3: nothing but the two key words moves the lock
  a_r2_lock_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (wa == 1 || wa == 2)) |=> $stable(lock_q));

  a_r4_locked_write_err: assert property (@(posedge clk) disable iff (rst)
    bus_wr && lock_q && (wa == 64 || wa == 68 || wa == 128) |-> access_err);

  a_r5_ro_write_err: assert property (@(posedge clk) disable iff (rst)
    bus_wr && (wa == 3 || wa == 67 || wa == 151) |-> access_err);

  a_r6_wo_read_err: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (wa == 1 || wa == 2) |-> access_err);

  a_r7_ctrl_no_err: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !bus_rd && wa == 0 |-> !access_err);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |=> !soft_rst_req);

  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |-> $past(bus_wr && wa == 128 && bus_wdata[0] && !lock_q));
endmodule

bind sysctl_lock_regs slr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .access_err(access_err), .soft_rst_req(soft_rst_req),
  .lock_q(lock_q)
);

// File: tb/sysctl_lock_regs_tb.sv
module sysctl_lock_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        access_err, soft_rst_req;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  sysctl_lock_regs u_dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .access_err(access_err),
    .soft_rst_req(soft_rst_req)
  );

  // 0 unmapped, 1 read-write, 2 read-only, 3 write-only
  function automatic int cls_of(int a);
    if (a >= 448 && a < 502) return 1;
    if (a == 1 || a == 2) return 3;
    if (a == 3 || a == 67 || a == 151) return 2;
    if (a == 0 || a == 128 || (a >= 64 && a <= 66) || (a >= 68 && a <= 70)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] rst_val(int a);
    if (a == 3 || a == 151) return 32'h1;
    if (a >= 64 && a <= 66) return 32'h0001A008;
    if (a >= 68 && a <= 70) return 32'h00014000;
    if (a == 67) return 32'h3F;
    return 32'h0;
  endfunction

  function automatic logic [31:0] pat(int a);
    return 32'h5A5A0000 | 32'(a);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                           output logic e, output logic s);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 e = access_err;
    @(negedge clk);
    bus_wr = 1'b0;
    s = soft_rst_req;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 e = access_err;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic print_summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      print_summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        e, s;
    int          c;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 soft_rst_req after reset", 32'(soft_rst_req), 0);
    check("R9 access_err idle", 32'(access_err), 0);
    check("R9 rdata after reset", bus_rdata, 0);

    // read sweep of reset contents
    for (int a = 0; a < 1024; a++) begin
      c = cls_of(a);
      bus_read(12'(a * 4), d, e);
      check($sformatf("R6 read err word %0d", a), 32'(e), 32'(c == 0 || c == 3));
      if (!(a >= 448 && a < 502))
        check($sformatf("R1 reset value word %0d", a), d, rst_val(a));
    end

    // locked write sweep
    for (int a = 0; a < 1024; a++) begin
      c = cls_of(a);
      bus_write(12'(a * 4), pat(a), e, s);
      check($sformatf("R4 R5 locked write err word %0d", a), 32'(e),
            32'(!(c == 3 || a == 0)));
      check($sformatf("R8 no soft reset word %0d", a), 32'(s), 0);
    end
    for (int a = 0; a < 502; a++) begin
      if (!(a >= 448)) begin
        bus_read(12'(a * 4), d, e);
        check($sformatf("R4 locked readback word %0d", a), d, rst_val(a));
      end
    end

    // R7: control word bypasses the lock, keeps bit 0
    bus_write(12'h000, 32'hFFFF_FFFF, e, s);
    check("R7 ctrl write err while locked", 32'(e), 0);
    bus_read(12'h000, d, e);
    check("R7 ctrl keeps bit0", d, 32'h1);
    bus_write(12'h000, 32'hFFFF_FFFE, e, s);
    bus_read(12'h000, d, e);
    check("R7 ctrl clears bit0", d, 32'h0);

    // R8: soft reset blocked while locked
    bus_write(12'h200, 32'h1, e, s);
    check("R4 locked reset-ctl err", 32'(e), 1);
    check("R8 locked reset-ctl no pulse", 32'(s), 0);

    // R3 / R2 key handling
    bus_write(12'h008, 32'h0000_DF0C, e, s);
    check("R3 wrong unlock key no err", 32'(e), 0);
    bus_read(12'h00C, d, e);
    check("R3 wrong unlock key keeps lock", d, 32'h1);
    bus_write(12'h008, 32'hABCD_DF0D, e, s);
    bus_read(12'h00C, d, e);
    check("R3 unlock key upper bits ignored", d, 32'h0);
    bus_write(12'h004, 32'h0000_767A, e, s);
    check("R2 wrong lock key no err", 32'(e), 0);
    bus_read(12'h00C, d, e);
    check("R2 wrong lock key no effect", d, 32'h0);
    bus_write(12'h004, 32'hFFFF_767B, e, s);
    bus_read(12'h00C, d, e);
    check("R2 lock key sets lock", d, 32'h1);
    bus_write(12'h008, 32'h0000_DF0D, e, s);
    bus_read(12'h00C, d, e);
    check("R3 unlock again", d, 32'h0);

    // R10: low address bits ignored
    bus_write(12'h103, 32'hCAFE_0001, e, s);
    check("R10 write via unaligned addr err", 32'(e), 0);
    bus_read(12'h102, d, e);
    check("R10 read via unaligned addr", d, 32'hCAFE_0001);
    bus_read(12'h100, d, e);
    check("R10 read aligned addr", d, 32'hCAFE_0001);

    // R8: soft reset pulse
    bus_write(12'h200, 32'h0000_0001, e, s);
    check("R8 reset-ctl write err", 32'(e), 0);
    check("R8 pulse high next cycle", 32'(s), 1);
    @(negedge clk);
    check("R8 pulse one cycle only", 32'(soft_rst_req), 0);
    bus_read(12'h200, d, e);
    check("R8 reset-ctl stores value", d, 32'h1);
    bus_write(12'h200, 32'h0000_0002, e, s);
    check("R8 bit0 clear no pulse", 32'(s), 0);

    // R9: rdata holds between reads
    bus_read(12'h25C, d, e);
    repeat (3) @(negedge clk);
    check("R9 rdata holds", bus_rdata, 32'h1);
    check("R9 err low when idle", 32'(access_err), 0);

    // unlocked write sweep
    for (int a = 0; a < 1024; a++) begin
      c = cls_of(a);
      bus_write(12'(a * 4), pat(a), e, s);
      check($sformatf("R5 unlocked write err word %0d", a), 32'(e), 32'(c == 0 || c == 2));
      check($sformatf("R8 sweep no pulse word %0d", a), 32'(s), 0);
    end
    for (int a = 0; a < 1024; a++) begin
      logic [31:0] x;
      c = cls_of(a);
      if (c == 1)      x = (a == 0) ? 32'h0 : pat(a);
      else if (c == 2) x = (a == 3) ? 32'h0 : rst_val(a);
      else             x = 32'h0;
      bus_read(12'(a * 4), d, e);
      if (a >= 448 && a < 502)
        check($sformatf("R11 array word %0d", a), d, x);
      else if ((a >= 64 && a <= 66) || (a >= 68 && a <= 70))
        check($sformatf("R12 pll word %0d", a), d, x);
      else
        check($sformatf("R5 R6 readback word %0d", a), d, x);
    end

    done = 1'b1;
    print_summary();
    $finish;
  end
endmodule